// File: doc/BRIEF.md
# Pipeline hazard stall and forwarding unit

This block guards read-after-write dependencies in a five-stage in-order pipeline: fetch, decode with register read, ALU, memory access and register write. It compares the source register numbers of the instruction sitting in decode with the destination numbers of the two older instructions in the ALU and memory stages. For each ALU operand it then picks a bypass source for the cycle in which the consumer reaches the ALU. When a bypass cannot deliver the value in time, it holds the front of the pipeline instead.

A load that is still in the ALU stage has no data yet. Its consumer waits one cycle in decode and then takes the value from the memory-stage bypass. While the unit stalls, the PC and the decode register keep their contents and the ALU stage receives a bubble with its control bits cleared. A mode input turns bypassing off. In that mode the consumer waits until its producer has passed the memory stage, and the register file's write-first behaviour covers the write-back stage.

A small model of the stage registers is built around the unit so that its decisions can be observed at the ports. Instructions enter decode over a valid/ready stream. The upstream side must hold its instruction and fields steady while `iss_valid` is high and `iss_ready` is low. A transfer happens on a rising edge where both are high. When no transfer happens, decode either holds (during a stall) or takes a bubble (no valid input). Source usage is flagged per operand, so instructions such as load-immediate do not create false dependencies.

Top module: `raw_guard_top`

## Requirements
- R1: After reset, `stall` is 0, `iss_ready` is 1 and `ex_valid` is 0.
- R2: With `fwd_en`=1, a consumer operand whose producer is the instruction directly ahead (not a load) reaches the ALU stage with select 2'b01 (ALU-stage result), and no stall is raised.
- R3: With `fwd_en`=1, a consumer operand whose producer is two instructions ahead reaches the ALU stage with select 2'b10 (memory-stage result), and no stall is raised.
- R4: An operand whose producer is three or more instructions ahead, or whose would-be producer does not write a register, gets select 2'b00 (register file) and causes no stall.
- R5: When both older instructions write the operand's register, the newer one wins: the select is 2'b01.
- R6: With `fwd_en`=1, a load immediately followed by a consumer of its destination stalls exactly one cycle. The consumer then reaches the ALU stage with select 2'b10.
- R7: While `stall` is high, `iss_ready` is low and decode keeps its instruction. The next cycle the ALU stage holds a bubble (`ex_valid`=0, selects 2'b00). Instructions still reach the ALU stage in issue order.
- R8: With `fwd_en`=0, the unit stalls while a matching producer is in the ALU or memory stage: two cycles for an adjacent producer, one cycle with one instruction in between. All selects are 2'b00.
- R9: An operand whose use flag is 0 never causes a stall or a bypass, even against a load in the ALU stage.
- R10: If one operand needs a load stall while the other matches a memory-stage producer, the stall wins. After the stall each select reflects the producer's new position: 2'b10 for the load, 2'b00 for a producer that has reached write-back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fwd_en | input | 1 | 1 = bypassing enabled, 0 = stall-only operation |
| iss_valid | input | 1 | An instruction is offered to decode |
| iss_ready | output | 1 | Decode accepts the offered instruction this cycle |
| iss_rd | input | REG_W | Destination register number |
| iss_we | input | 1 | Instruction writes its destination register |
| iss_ld | input | 1 | Instruction is a load (value available only after memory stage) |
| iss_ra | input | REG_W | First source register number |
| iss_use_a | input | 1 | First source register is read |
| iss_rb | input | REG_W | Second source register number |
| iss_use_b | input | 1 | Second source register is read |
| stall | output | 1 | Fetch and decode frozen, bubble goes into the ALU stage |
| ex_valid | output | 1 | ALU stage holds a real instruction |
| ex_rd | output | REG_W | Destination number of the instruction in the ALU stage |
| ex_sel_a | output | 2 | Operand A source: 00 register file, 01 ALU-stage result, 10 memory-stage result |
| ex_sel_b | output | 2 | Operand B source, same encoding |

## Verification
Two functions can fall in the same cycle: the load-use stall and the memory-stage bypass, each hit by a different operand of one consumer. The bench provokes this with an ALU producer, a load and then a consumer that reads both destinations. It judges the result by counting exactly one stall cycle and one bubble. It then checks that operand A arrives with the memory-stage select and operand B with the register-file select, because its producer moved on to write-back during the stall. The bypass priority case is provoked in a similar way: two back-to-back writers of the same register both match the consumer, and the bench checks that the newer one wins.

// File: rtl/raw_pkg.sv
package raw_pkg;

  // Operand source select carried into the ALU stage
  typedef enum logic [1:0] {
    SEL_RF  = 2'd0,  // register file (write-first)
    SEL_ALU = 2'd1,  // result latched at the end of the ALU stage
    SEL_MEM = 2'd2   // result latched at the end of the memory stage
  } opnd_sel_e;

  localparam int unsigned SEL_W = 2;

endpackage

// File: rtl/raw_match.sv
// Compares one decode source against one older producer.
module raw_match #(
  parameter int unsigned REG_W = 5
) (
  input  logic             src_en,
  input  logic [REG_W-1:0] src_num,
  input  logic             prod_v,
  input  logic             prod_we,
  input  logic [REG_W-1:0] prod_rd,
  output logic             hit
);

  logic same_num;

  assign same_num = (src_num == prod_rd);
  assign hit      = src_en & prod_v & prod_we & same_num;

endmodule

// File: rtl/raw_opnd_ctl.sv
// Per-operand decision: bypass source and stall request.
module raw_opnd_ctl
  import raw_pkg::*;
#(
  parameter int unsigned REG_W = 5
) (
  input  logic             fwd_en,
  input  logic             id_v,
  input  logic             use_src,
  input  logic [REG_W-1:0] src_num,
  input  logic             ex_v,
  input  logic             ex_we,
  input  logic             ex_ld,
  input  logic [REG_W-1:0] ex_rd,
  input  logic             mem_v,
  input  logic             mem_we,
  input  logic [REG_W-1:0] mem_rd,
  output logic [SEL_W-1:0] sel,
  output logic             need_stall
);

  logic      src_live;
  logic      hit_ex;
  logic      hit_mem;
  opnd_sel_e pick;

  assign src_live = id_v & use_src;

  raw_match #(.REG_W(REG_W)) u_m_ex (
    .src_en (src_live),
    .src_num(src_num),
    .prod_v (ex_v),
    .prod_we(ex_we),
    .prod_rd(ex_rd),
    .hit    (hit_ex)
  );

  raw_match #(.REG_W(REG_W)) u_m_mem (
    .src_en (src_live),
    .src_num(src_num),
    .prod_v (mem_v),
    .prod_we(mem_we),
    .prod_rd(mem_rd),
    .hit    (hit_mem)
  );

  always_comb begin
    pick       = SEL_RF;
    need_stall = 1'b0;
    if (fwd_en) begin
      // newest producer has priority
      if (hit_ex) begin
        pick       = SEL_ALU;
        need_stall = ex_ld;
      end else if (hit_mem) begin
        pick = SEL_MEM;
      end
    end else begin
      // stall-only: wait until producer reaches write-back
      need_stall = hit_ex | hit_mem;
    end
  end

  assign sel = pick;

endmodule

// File: rtl/raw_hazard_unit.sv
// Hazard detection across all decode operands.
module raw_hazard_unit
  import raw_pkg::*;
#(
  parameter int unsigned REG_W = 5,
  parameter int unsigned NOPND = 2
) (
  input  logic                        fwd_en,
  input  logic                        id_v,
  input  logic [NOPND-1:0][REG_W-1:0] id_src,
  input  logic [NOPND-1:0]            id_use,
  input  logic                        ex_v,
  input  logic                        ex_we,
  input  logic                        ex_ld,
  input  logic [REG_W-1:0]            ex_rd,
  input  logic                        mem_v,
  input  logic                        mem_we,
  input  logic [REG_W-1:0]            mem_rd,
  output logic [NOPND-1:0][SEL_W-1:0] sel,
  output logic                        stall
);

  logic [NOPND-1:0] opnd_stall;

  for (genvar g = 0; g < NOPND; g++) begin : g_opnd
    raw_opnd_ctl #(.REG_W(REG_W)) u_ctl (
      .fwd_en    (fwd_en),
      .id_v      (id_v),
      .use_src   (id_use[g]),
      .src_num   (id_src[g]),
      .ex_v      (ex_v),
      .ex_we     (ex_we),
      .ex_ld     (ex_ld),
      .ex_rd     (ex_rd),
      .mem_v     (mem_v),
      .mem_we    (mem_we),
      .mem_rd    (mem_rd),
      .sel       (sel[g]),
      .need_stall(opnd_stall[g])
    );
  end

  assign stall = |opnd_stall;

endmodule

// File: rtl/raw_stage_pipe.sv
// Decode, ALU and memory stage registers of the pipeline model.
module raw_stage_pipe
  import raw_pkg::*;
#(
  parameter int unsigned REG_W = 5,
  parameter int unsigned NOPND = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        stall,
  input  logic                        in_valid,
  input  logic [REG_W-1:0]            in_rd,
  input  logic                        in_we,
  input  logic                        in_ld,
  input  logic [NOPND-1:0][REG_W-1:0] in_src,
  input  logic [NOPND-1:0]            in_use,
  input  logic [NOPND-1:0][SEL_W-1:0] id_sel,
  output logic                        id_v,
  output logic [REG_W-1:0]            id_rd,
  output logic [NOPND-1:0][REG_W-1:0] id_src,
  output logic [NOPND-1:0]            id_use,
  output logic                        ex_v,
  output logic [REG_W-1:0]            ex_rd,
  output logic                        ex_we,
  output logic                        ex_ld,
  output logic [NOPND-1:0][SEL_W-1:0] ex_sel,
  output logic                        mem_v,
  output logic [REG_W-1:0]            mem_rd,
  output logic                        mem_we
);

  logic id_we;
  logic id_ld;
  logic pass_id;

  // decode moves on only when not frozen and it holds something real
  assign pass_id = ~stall & id_v;

  // decode register: holds during a stall
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      id_v   <= 1'b0;
      id_rd  <= '0;
      id_we  <= 1'b0;
      id_ld  <= 1'b0;
      id_src <= '0;
      id_use <= '0;
    end else if (!stall) begin
      id_v   <= in_valid;
      id_rd  <= in_rd;
      id_we  <= in_valid & in_we;
      id_ld  <= in_valid & in_ld;
      id_src <= in_src;
      id_use <= in_valid ? in_use : '0;
    end
  end

  // ALU stage register: bubble on stall or empty decode
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ex_v   <= 1'b0;
      ex_rd  <= '0;
      ex_we  <= 1'b0;
      ex_ld  <= 1'b0;
      ex_sel <= '0;
    end else if (pass_id) begin
      ex_v   <= 1'b1;
      ex_rd  <= id_rd;
      ex_we  <= id_we;
      ex_ld  <= id_ld;
      ex_sel <= id_sel;
    end else begin
      ex_v   <= 1'b0;
      ex_rd  <= '0;
      ex_we  <= 1'b0;
      ex_ld  <= 1'b0;
      ex_sel <= '0;
    end
  end

  // memory stage register: always advances
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_v  <= 1'b0;
      mem_rd <= '0;
      mem_we <= 1'b0;
    end else begin
      mem_v  <= ex_v;
      mem_rd <= ex_rd;
      mem_we <= ex_we;
    end
  end

endmodule

// File: rtl/raw_guard_top.sv
module raw_guard_top
  import raw_pkg::*;
#(
  parameter int unsigned REG_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fwd_en,
  input  logic             iss_valid,
  output logic             iss_ready,
  input  logic [REG_W-1:0] iss_rd,
  input  logic             iss_we,
  input  logic             iss_ld,
  input  logic [REG_W-1:0] iss_ra,
  input  logic             iss_use_a,
  input  logic [REG_W-1:0] iss_rb,
  input  logic             iss_use_b,
  output logic             stall,
  output logic             ex_valid,
  output logic [REG_W-1:0] ex_rd,
  output logic [1:0]       ex_sel_a,
  output logic [1:0]       ex_sel_b
);

  localparam int unsigned NOPND = 2;
  localparam int unsigned OA    = 0;
  localparam int unsigned OB    = 1;

  logic [NOPND-1:0][REG_W-1:0] in_src;
  logic [NOPND-1:0]            in_use;
  logic                        id_v;
  logic [REG_W-1:0]            id_rd;
  logic [NOPND-1:0][REG_W-1:0] id_src;
  logic [NOPND-1:0]            id_use;
  logic [NOPND-1:0][SEL_W-1:0] id_sel;
  logic                        ex_v;
  logic                        ex_we;
  logic                        ex_ld;
  logic [REG_W-1:0]            ex_rd_q;
  logic [NOPND-1:0][SEL_W-1:0] ex_sel;
  logic                        mem_v;
  logic [REG_W-1:0]            mem_rd;
  logic                        mem_we;
  logic                        hz_stall;

  assign in_src[OA] = iss_ra;
  assign in_src[OB] = iss_rb;
  assign in_use[OA] = iss_use_a;
  assign in_use[OB] = iss_use_b;

  raw_hazard_unit #(.REG_W(REG_W), .NOPND(NOPND)) u_hz (
    .fwd_en(fwd_en),
    .id_v  (id_v),
    .id_src(id_src),
    .id_use(id_use),
    .ex_v  (ex_v),
    .ex_we (ex_we),
    .ex_ld (ex_ld),
    .ex_rd (ex_rd_q),
    .mem_v (mem_v),
    .mem_we(mem_we),
    .mem_rd(mem_rd),
    .sel   (id_sel),
    .stall (hz_stall)
  );

  raw_stage_pipe #(.REG_W(REG_W), .NOPND(NOPND)) u_pipe (
    .clk     (clk),
    .rst_n   (rst_n),
    .stall   (hz_stall),
    .in_valid(iss_valid),
    .in_rd   (iss_rd),
    .in_we   (iss_we),
    .in_ld   (iss_ld),
    .in_src  (in_src),
    .in_use  (in_use),
    .id_sel  (id_sel),
    .id_v    (id_v),
    .id_rd   (id_rd),
    .id_src  (id_src),
    .id_use  (id_use),
    .ex_v    (ex_v),
    .ex_rd   (ex_rd_q),
    .ex_we   (ex_we),
    .ex_ld   (ex_ld),
    .ex_sel  (ex_sel),
    .mem_v   (mem_v),
    .mem_rd  (mem_rd),
    .mem_we  (mem_we)
  );

  assign stall     = hz_stall;
  assign iss_ready = ~hz_stall;
  assign ex_valid  = ex_v;
  assign ex_rd     = ex_rd_q;
  assign ex_sel_a  = ex_sel[OA];
  assign ex_sel_b  = ex_sel[OB];

endmodule

// File: rtl/raw_guard_chk.sv
module raw_guard_chk #(
  parameter int unsigned REG_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             fwd_en,
  input logic             stall,
  input logic             ex_valid,
  input logic [1:0]       ex_sel_a,
  input logic [1:0]       ex_sel_b,
  input logic             id_v,
  input logic [REG_W-1:0] id_rd
);

  // R7: a stall puts a bubble into the ALU stage
  p_bubble_r7: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> !ex_valid);

  // R7: decode keeps its instruction across a stall
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> (id_v && $stable(id_rd)));

  // R7: a bubble carries no bypass select
  p_bubble_sel_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !ex_valid |-> (ex_sel_a == 2'b00 && ex_sel_b == 2'b00));

  // R6: with bypassing on, a stall never lasts more than one cycle
  p_one_stall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && fwd_en) |=> !stall);

  // R8: stall-only mode never stalls three cycles in a row
  p_two_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && $past(stall)) |=> !stall);

  // R8: stall-only mode issues register-file selects only
  p_rf_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !fwd_en |=> (ex_sel_a == 2'b00 && ex_sel_b == 2'b00));

  // R2: select code 2'b11 is never produced
  p_sel_code_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_sel_a != 2'b11) && (ex_sel_b != 2'b11));

endmodule

bind raw_guard_top raw_guard_chk #(.REG_W(REG_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .fwd_en  (fwd_en),
  .stall   (stall),
  .ex_valid(ex_valid),
  .ex_sel_a(ex_sel_a),
  .ex_sel_b(ex_sel_b),
  .id_v    (id_v),
  .id_rd   (id_rd)
);

// File: tb/sim_raw_guard_top.sv
`timescale 1ns/1ps
module sim_raw_guard_top;

  localparam int W = 5;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         fwd_en = 1'b1;
  logic         iss_valid = 1'b0;
  logic         iss_ready;
  logic [W-1:0] iss_rd = '0;
  logic         iss_we = 1'b0;
  logic         iss_ld = 1'b0;
  logic [W-1:0] iss_ra = '0;
  logic         iss_use_a = 1'b0;
  logic [W-1:0] iss_rb = '0;
  logic         iss_use_b = 1'b0;
  logic         stall;
  logic         ex_valid;
  logic [W-1:0] ex_rd;
  logic [1:0]   ex_sel_a;
  logic [1:0]   ex_sel_b;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  // observation results
  int g_wait;
  int w_stalls, w_bub, w_idx1, w_idx2, w_sa, w_sb;

  always #10 clk = ~clk;

  raw_guard_top #(.REG_W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .fwd_en(fwd_en),
    .iss_valid(iss_valid), .iss_ready(iss_ready),
    .iss_rd(iss_rd), .iss_we(iss_we), .iss_ld(iss_ld),
    .iss_ra(iss_ra), .iss_use_a(iss_use_a),
    .iss_rb(iss_rb), .iss_use_b(iss_use_b),
    .stall(stall), .ex_valid(ex_valid), .ex_rd(ex_rd),
    .ex_sel_a(ex_sel_a), .ex_sel_b(ex_sel_b)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // offer one instruction; counts cycles spent with ready low
  task automatic issue(input int rd, input bit we, input bit ld,
                       input int ra, input bit ua, input int rb, input bit ub);
    @(negedge clk);
    iss_valid = 1'b1;
    iss_rd = W'(rd); iss_we = we; iss_ld = ld;
    iss_ra = W'(ra); iss_use_a = ua;
    iss_rb = W'(rb); iss_use_b = ub;
    while (!iss_ready) begin
      g_wait++;
      @(negedge clk);
    end
    @(posedge clk);
  endtask

  // idle the input and watch the ALU stage for n cycles
  task automatic watch(input int tag1, input int tag2, input int n);
    w_stalls = 0; w_bub = 0; w_idx1 = -1; w_idx2 = -1; w_sa = -1; w_sb = -1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      iss_valid = 1'b0;
      if (stall) w_stalls++;
      if (!ex_valid && w_idx1 < 0 && i > 0) w_bub++;
      if (ex_valid && int'(ex_rd) == tag1 && w_idx1 < 0) begin
        w_idx1 = i; w_sa = int'(ex_sel_a); w_sb = int'(ex_sel_b);
      end
      if (ex_valid && int'(ex_rd) == tag2 && w_idx2 < 0) w_idx2 = i;
    end
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R1 stall", int'(stall), 0);
    chk("R1 ready", int'(iss_ready), 1);
    chk("R1 ex_valid", int'(ex_valid), 0);
  endtask

  task automatic t_adjacent_alu;  // R2
    g_wait = 0;
    issue(3, 1, 0, 7, 1, 8, 1);
    issue(4, 1, 0, 1, 1, 3, 1);
    watch(4, 31, 7);
    chk("R2 stalls", w_stalls, 0);
    chk("R2 sel_b alu", w_sb, 1);
    chk("R2 sel_a rf", w_sa, 0);
  endtask

  task automatic t_one_gap;  // R3
    issue(5, 1, 0, 1, 1, 2, 1);
    issue(6, 1, 0, 7, 1, 8, 1);
    issue(11, 1, 0, 5, 1, 9, 1);
    watch(11, 31, 7);
    chk("R3 stalls", w_stalls, 0);
    chk("R3 sel_a mem", w_sa, 2);
  endtask

  task automatic t_far_and_nowrite;  // R4
    issue(5, 1, 0, 1, 1, 2, 1);
    issue(6, 1, 0, 7, 1, 8, 1);
    issue(14, 1, 0, 7, 1, 8, 1);
    issue(15, 1, 0, 9, 1, 5, 1);
    watch(15, 31, 7);
    chk("R4 far sel_b", w_sb, 0);
    chk("R4 far stalls", w_stalls, 0);
    issue(16, 0, 1, 1, 1, 2, 1);
    issue(17, 1, 0, 16, 1, 16, 1);
    watch(17, 31, 7);
    chk("R4 nowrite sel_a", w_sa, 0);
    chk("R4 nowrite stalls", w_stalls, 0);
  endtask

  task automatic t_priority;  // R5
    issue(10, 1, 0, 1, 1, 2, 1);
    issue(10, 1, 0, 3, 1, 4, 1);
    issue(18, 1, 0, 10, 1, 10, 1);
    watch(18, 31, 7);
    chk("R5 sel_a newest", w_sa, 1);
    chk("R5 sel_b newest", w_sb, 1);
  endtask

  task automatic t_load_use;  // R6, R7
    g_wait = 0;
    issue(9, 1, 1, 1, 1, 2, 0);
    issue(20, 1, 0, 9, 1, 3, 1);
    issue(21, 1, 0, 4, 1, 5, 1);
    chk("R7 ready low while stalled", g_wait, 1);
    watch(20, 21, 7);
    chk("R6 sel_a mem after stall", w_sa, 2);
    chk("R7 order kept", int'(w_idx2 == w_idx1 + 1), 1);
    g_wait = 0;
    issue(9, 1, 1, 1, 1, 2, 0);
    issue(22, 1, 0, 9, 1, 3, 1);
    watch(22, 31, 7);
    chk("R6 one stall", w_stalls, 1);
    chk("R7 one bubble", w_bub, 1);
  endtask

  task automatic t_unused;  // R9
    issue(9, 1, 1, 1, 1, 2, 0);
    issue(23, 1, 0, 30, 1, 9, 0);
    watch(23, 31, 7);
    chk("R9 stalls", w_stalls, 0);
    chk("R9 sel_b", w_sb, 0);
    chk("R9 bubbles", w_bub, 0);
  endtask

  task automatic t_combined;  // R10
    issue(12, 1, 0, 1, 1, 2, 1);
    issue(13, 1, 1, 3, 1, 4, 0);
    issue(24, 1, 0, 13, 1, 12, 1);
    watch(24, 31, 7);
    chk("R10 stalls", w_stalls, 1);
    chk("R10 sel_a load", w_sa, 2);
    chk("R10 sel_b moved to rf", w_sb, 0);
  endtask

  task automatic t_stall_only;  // R8
    @(negedge clk);
    fwd_en = 1'b0;
    issue(3, 1, 0, 7, 1, 8, 1);
    issue(25, 1, 0, 3, 1, 1, 1);
    watch(25, 31, 8);
    chk("R8 adjacent stalls", w_stalls, 2);
    chk("R8 adjacent sel_a", w_sa, 0);
    chk("R8 adjacent bubbles", w_bub, 2);
    issue(5, 1, 0, 7, 1, 8, 1);
    issue(6, 1, 0, 7, 1, 8, 1);
    issue(26, 1, 0, 1, 1, 5, 1);
    watch(26, 31, 8);
    chk("R8 one gap stalls", w_stalls, 1);
    chk("R8 one gap sel_b", w_sb, 0);
    issue(9, 1, 1, 1, 1, 2, 0);
    issue(27, 1, 0, 9, 1, 9, 1);
    watch(27, 31, 8);
    chk("R8 load stalls", w_stalls, 2);
    @(negedge clk);
    fwd_en = 1'b1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_adjacent_alu();
    t_one_gap();
    t_far_and_nowrite();
    t_priority();
    t_load_use();
    t_unused();
    t_combined();
    t_stall_only();
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule